// File: doc/BRIEF.md
# Adjustable Time-of-Day Counter

This block keeps precision network time as three 32-bit words: seconds, nanoseconds within the second, and a fraction of a nanosecond in units of 2^-32 ns. On every clock cycle the counter adds a nominal period plus or minus a trim. Software uses the trim to speed the clock up or slow it down. When the nanosecond word reaches one billion, it wraps and the seconds word counts up.

Software reaches the counter through a 32-bit register port with a request channel and a response channel, each using valid/ready. A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. A read returns one response on the next cycle. A write returns no response. `req_ready` is low only while a read response is waiting and `rsp_ready` is low. While it waits, the response keeps its data. Reading the fraction word takes a coherent picture of the time: the seconds and nanoseconds read after it belong to the same instant. Setting the time stages the nanoseconds and, optionally, the fraction. The write of the seconds word then commits all three words at once. A coarse step is done by software as a read, an add and a write-back.

Top module: `tod_counter`

## Requirements
- R1: After reset the live time, the snapshot, the staged words and the trim register are zero. `rsp_valid` is low and `req_ready` is high.
- R2: Each cycle the combined {nanoseconds, fraction} value grows by a step. The step is NOM_NS ns plus NOM_FRAC·2^-32 ns, adjusted by the trim's 31-bit magnitude (bits 30:0) in units of 2^-32 ns. Trim bit 31 = 0 adds the magnitude; bit 31 = 1 subtracts it and slows the clock. Carries and borrows propagate from the fraction into nanoseconds.
- R3: When nanoseconds reach or pass 1,000,000,000, 1,000,000,000 is subtracted and seconds increase by one in the same cycle. Otherwise seconds hold.
- R4: A read of address 0 returns the live fraction as it stood at the accepting edge. The same read latches the live nanoseconds and seconds into a snapshot. Reads of address 1 (nanoseconds) and address 2 (seconds) return that snapshot.
- R5: The snapshot holds until the next address-0 read, while the live counter keeps running.
- R6: A write to address 1 only stages nanoseconds and leaves the live time untouched. A write to address 2 loads seconds from the write data, nanoseconds from the staged word and the fraction from the staged fraction, all in one cycle. That cycle replaces counting.
- R7: A write to address 0 stages the fraction. Each commit clears the staged fraction, so a commit with no fraction write since the previous one loads a fraction of zero.
- R8: Address 3 is the trim register. Writes store all 32 bits and reads return them unchanged.
- R9: A read produces exactly one response, valid on the cycle after acceptance. A write produces none. While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low and `rsp_data` holds.
- R10: With the default 8 ns period, the largest magnitude (2^31−1) shifts the rate by about 62.5 million parts per billion in either direction and is applied exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2 | Word select: 0 fraction, 1 nanoseconds, 2 seconds, 3 trim |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Consumer takes read data |
| rsp_data | output | 32 | Read data |

## Verification
On every cycle, assertions check three things: nanoseconds stay below one billion once counting, seconds advance by at most one per cycle, and a commit lands the staged words exactly. They also check that the snapshot holds between fraction reads and that a stalled response holds its data. Only the bench's scenarios can show that the counted value is right. The bench sweeps trim values (zero, ±1, the extreme magnitudes, negative zero), start points near the second boundary and elapsed cycle counts. It compares each snapshot against time computed arithmetically, and it also checks fraction staging and back-pressure.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned STEP_W = 2 * WORD_W;
  localparam logic [WORD_W-1:0] NS_PER_SEC = 32'd1_000_000_000;

  typedef enum logic [1:0] {
    SEL_FRAC = 2'd0,
    SEL_NS   = 2'd1,
    SEL_SEC  = 2'd2,
    SEL_TRIM = 2'd3
  } word_sel_e;
endpackage

// File: rtl/tod_step_gen.sv
module tod_step_gen
  import tod_pkg::*;
#(
  parameter int unsigned NOM_NS   = 8,
  parameter int unsigned NOM_FRAC = 0
) (
  input  logic [WORD_W-1:0] trim,
  output logic [STEP_W-1:0] step
);
  localparam logic [STEP_W-1:0] NOMINAL =
    (STEP_W'(NOM_NS) << WORD_W) | STEP_W'(NOM_FRAC);

  logic [STEP_W-1:0] mag;
  assign mag = {{(STEP_W-WORD_W+1){1'b0}}, trim[WORD_W-2:0]};

  // sign bit set: slow down
  always_comb begin
    if (trim[WORD_W-1]) step = NOMINAL - mag;
    else                step = NOMINAL + mag;
  end
endmodule

// File: rtl/tod_accum.sv
module tod_accum
  import tod_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STEP_W-1:0] step,
  input  logic              load,
  input  logic [WORD_W-1:0] load_sec,
  input  logic [WORD_W-1:0] load_ns,
  input  logic [WORD_W-1:0] load_frac,
  output logic [WORD_W-1:0] sec_q,
  output logic [WORD_W-1:0] ns_q,
  output logic [WORD_W-1:0] frac_q
);
  logic [STEP_W:0]   sum;
  logic [WORD_W:0]   ns_sum;
  logic              wrap;
  logic [WORD_W-1:0] ns_d;

  assign sum    = {1'b0, ns_q, frac_q} + {1'b0, step};
  assign ns_sum = sum[STEP_W:WORD_W];
  assign wrap   = ns_sum >= {1'b0, NS_PER_SEC};
  assign ns_d   = wrap ? (ns_sum[WORD_W-1:0] - NS_PER_SEC) : ns_sum[WORD_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_q  <= '0;
      ns_q   <= '0;
      frac_q <= '0;
    end else if (load) begin
      sec_q  <= load_sec;
      ns_q   <= load_ns;
      frac_q <= load_frac;
    end else begin
      frac_q <= sum[WORD_W-1:0];
      ns_q   <= ns_d;
      if (wrap) sec_q <= sec_q + 1'b1;
    end
  end

  AST_NS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && ns_q < NS_PER_SEC) |=> ns_q < NS_PER_SEC); // R3
  AST_SEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (sec_q == $past(sec_q) || sec_q == $past(sec_q) + 32'd1)); // R3
  AST_LOAD_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (sec_q == $past(load_sec) && ns_q == $past(load_ns) && frac_q == $past(load_frac))); // R6
endmodule

// File: rtl/tod_regif.sv
module tod_regif
  import tod_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [WORD_W-1:0] rsp_data,
  input  logic [WORD_W-1:0] live_sec,
  input  logic [WORD_W-1:0] live_ns,
  input  logic [WORD_W-1:0] live_frac,
  output logic [WORD_W-1:0] trim,
  output logic              load,
  output logic [WORD_W-1:0] load_sec,
  output logic [WORD_W-1:0] load_ns,
  output logic [WORD_W-1:0] load_frac
);
  logic              rsp_valid_q;
  logic [WORD_W-1:0] rsp_data_q;
  logic [WORD_W-1:0] snap_ns, snap_sec;
  logic [WORD_W-1:0] stage_ns, stage_frac;
  logic [WORD_W-1:0] trim_q;
  logic              accept, rd, wr;
  word_sel_e         sel;
  logic [WORD_W-1:0] rd_mux;

  assign sel       = word_sel_e'(req_addr);
  assign req_ready = !rsp_valid_q || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign rd        = accept && !req_write;
  assign wr        = accept && req_write;

  always_comb begin
    unique case (sel)
      SEL_FRAC: rd_mux = live_frac;
      SEL_NS:   rd_mux = snap_ns;
      SEL_SEC:  rd_mux = snap_sec;
      default:  rd_mux = trim_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
      snap_ns     <= '0;
      snap_sec    <= '0;
      stage_ns    <= '0;
      stage_frac  <= '0;
      trim_q      <= '0;
    end else begin
      if (rd) begin
        rsp_valid_q <= 1'b1;
        rsp_data_q  <= rd_mux;
      end else if (rsp_ready) begin
        rsp_valid_q <= 1'b0;
      end
      if (rd && sel == SEL_FRAC) begin
        snap_ns  <= live_ns;
        snap_sec <= live_sec;
      end
      if (wr) begin
        unique case (sel)
          SEL_FRAC: stage_frac <= req_wdata;
          SEL_NS:   stage_ns   <= req_wdata;
          SEL_SEC:  stage_frac <= '0;
          default:  trim_q     <= req_wdata;
        endcase
      end
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;
  assign trim      = trim_q;
  assign load      = wr && sel == SEL_SEC;
  assign load_sec  = req_wdata;
  assign load_ns   = stage_ns;
  assign load_frac = stage_frac;

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data))); // R9
  AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> !rsp_valid); // R9
  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd && sel == SEL_FRAC) |=> ($stable(snap_ns) && $stable(snap_sec))); // R5
endmodule

// File: rtl/tod_counter.sv
module tod_counter
  import tod_pkg::*;
#(
  parameter int unsigned NOM_NS   = 8,
  parameter int unsigned NOM_FRAC = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [1:0]  req_addr,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [31:0] rsp_data
);
  logic [WORD_W-1:0] trim;
  logic [STEP_W-1:0] step;
  logic              load;
  logic [WORD_W-1:0] load_sec, load_ns, load_frac;
  logic [WORD_W-1:0] sec_q, ns_q, frac_q;

  tod_step_gen #(.NOM_NS(NOM_NS), .NOM_FRAC(NOM_FRAC)) u_step (
    .trim (trim),
    .step (step)
  );

  tod_accum u_accum (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (step),
    .load      (load),
    .load_sec  (load_sec),
    .load_ns   (load_ns),
    .load_frac (load_frac),
    .sec_q     (sec_q),
    .ns_q      (ns_q),
    .frac_q    (frac_q)
  );

  tod_regif u_regif (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_data  (rsp_data),
    .live_sec  (sec_q),
    .live_ns   (ns_q),
    .live_frac (frac_q),
    .trim      (trim),
    .load      (load),
    .load_sec  (load_sec),
    .load_ns   (load_ns),
    .load_frac (load_frac)
  );
endmodule

// File: tb/sim_tod_counter.sv
module sim_tod_counter;
  localparam int CLK_PERIOD = 10;
  localparam int NOM = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [1:0]  req_addr = 2'd0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [31:0] rsp_data;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tod_counter #(.NOM_NS(NOM), .NOM_FRAC(0)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_data;
    chk("R9", "read response valid", {31'd0, rsp_valid}, 32'd1);
  endtask

  task automatic idle(input int m);
    repeat (m) @(negedge clk);
  endtask

  // expected time after m steps from loaded {x, f} at second s
  task automatic predict(input logic [31:0] x, f, s, trim, input int m,
                         output logic [31:0] ef, en, es);
    logic [95:0] tot;
    logic [63:0] stp, nsall;
    stp = trim[31] ? ((64'(NOM) << 32) - 64'(trim[30:0])) : ((64'(NOM) << 32) + 64'(trim[30:0]));
    tot = {32'd0, x, f} + 96'(m) * {32'd0, stp};
    ef = tot[31:0];
    nsall = tot[95:32];
    es = s + 32'(nsall / 64'd1_000_000_000);
    en = 32'(nsall % 64'd1_000_000_000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, ef, en, es, f0, n0, s0;
    logic [31:0] trims [6];
    logic [31:0] starts [4];
    int steps [4];
    trims = '{32'd0, 32'd1, 32'h7FFF_FFFF, 32'h8000_0001, 32'hFFFF_FFFF, 32'h8000_0000};
    starts = '{32'd0, 32'd999_999_990, 32'd999_999_999, 32'd123_456_789};
    steps = '{0, 1, 2, 5};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk("R1", "req_ready", {31'd0, req_ready}, 32'd1);
    rd(2'd3, d); chk("R1", "trim", d, 32'd0);
    rd(2'd1, d); chk("R1", "snapshot ns", d, 32'd0);
    rd(2'd2, d); chk("R1", "snapshot sec", d, 32'd0);

    // R2 R3 R10 sweep over trim, start point and elapsed steps
    for (int t = 0; t < 6; t++) begin
      for (int x = 0; x < 4; x++) begin
        for (int k = 0; k < 4; k++) begin
          logic [31:0] fr, sc;
          fr = x[0] ? 32'hFFFF_FFF0 : 32'h0000_0010;
          sc = 32'd100 + 32'(t * 16 + x * 4 + k);
          wr(2'd3, trims[t]);
          wr(2'd0, fr);
          wr(2'd1, starts[x]);
          wr(2'd2, sc);
          idle(steps[k]);
          predict(starts[x], fr, sc, trims[t], steps[k], ef, en, es);
          rd(2'd0, d); chk("R2", "fraction", d, ef);
          rd(2'd1, d); chk("R3", "nanoseconds", d, en);
          rd(2'd2, d); chk("R3", "seconds", d, es);
        end
      end
    end

    // R8 trim readback of every bit
    wr(2'd3, 32'hA5C3_0F96); rd(2'd3, d); chk("R8", "trim readback", d, 32'hA5C3_0F96);
    wr(2'd3, 32'h0000_0000); rd(2'd3, d); chk("R8", "trim cleared", d, 32'h0);

    // R7 fraction staged then cleared by commit
    wr(2'd0, 32'hABCD_0000); wr(2'd1, 32'd5); wr(2'd2, 32'd1);
    rd(2'd0, d); chk("R7", "staged fraction loaded", d, 32'hABCD_0000);
    wr(2'd1, 32'd7); wr(2'd2, 32'd2);
    rd(2'd0, d); chk("R7", "fraction zero after commit", d, 32'd0);
    rd(2'd1, d); chk("R7", "ns loaded", d, 32'd7);
    rd(2'd2, d); chk("R7", "sec loaded", d, 32'd2);

    // R6 nanosecond write leaves live time alone; R4 R5 snapshot hold
    wr(2'd1, 32'd999_999_000); wr(2'd2, 32'd40);
    wr(2'd1, 32'd11);
    predict(32'd999_999_000, 32'd0, 32'd40, 32'd0, 1, ef, en, es);
    rd(2'd0, d); chk("R6", "fraction after ns-only write", d, ef);
    rd(2'd1, d); chk("R6", "ns after ns-only write", d, en);
    rd(2'd2, d); chk("R6", "sec after ns-only write", d, es);
    n0 = en;
    idle(20);
    rd(2'd1, d); chk("R5", "snapshot ns held", d, n0);
    rd(2'd0, f0);
    predict(32'd999_999_000, 32'd0, 32'd40, 32'd0, 1 + 24, ef, en, es);
    chk("R4", "fraction at second read", f0, ef);
    rd(2'd1, d); chk("R4", "new snapshot ns", d, en);
    rd(2'd2, s0); chk("R4", "new snapshot sec", s0, es);

    // R9 back-pressure and silent writes
    wr(2'd3, 32'h0000_1234);
    chk("R9", "no response to write", {31'd0, rsp_valid}, 32'd0);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 2'd3;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    chk("R9", "stalled valid", {31'd0, rsp_valid}, 32'd1);
    chk("R9", "stalled data", rsp_data, 32'h0000_1234);
    chk("R9", "ready low while stalled", {31'd0, req_ready}, 32'd0);
    idle(2);
    chk("R9", "still valid", {31'd0, rsp_valid}, 32'd1);
    chk("R9", "data held", rsp_data, 32'h0000_1234);
    rsp_ready = 1'b1;
    idle(1);
    chk("R9", "drained", {31'd0, rsp_valid}, 32'd0);
    chk("R9", "ready restored", {31'd0, req_ready}, 32'd1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule